// File: doc/BRIEF.md
# Serial Command and Display-RAM Loader

This block is the host-facing front end of a small character/annunciator display controller. The host shifts 8-bit bytes in over a serial link made of a chip-select, a serial clock, a serial data line and a command/data select line. Each byte is either a command or a display-data byte. Commands load a shared write pointer, set the display flags and the blink-granularity mode, enable the serial output driver, write blink bits, or clear the memories. Data bytes go into the memory picked by the pointer. Every write that lands moves the pointer on by one.

There are four register-file memories of thirteen cells each. The character-code memory and the character-blink memory sit in pointer area 0 (pointer bit 4 clear). The annunciator-dot memory and the annunciator-blink memory sit in area 1 (pointer bit 4 set). In each area, the cell index just past the last valid cell is a guard position: a write there is thrown away and the pointer stays where it is. A display scan engine reads the memories through two combinational read ports, one for each area. The block also rejects bytes that arrive too soon after the previous accepted byte and marks each rejection with an error pulse.

Top module: `lcd_cmd_loader`

## Requirements
- R1: Serial bits are taken on rising edges of `sclk` while `cs_n` is low, least significant bit first, and eight bits make a byte. Raising `cs_n` throws away a partly received byte.
- R2: A byte received with `cmd_sel` high is a command. A byte received with `cmd_sel` low is display data.
- R3: The command opcode is held in bits 7:5. Opcode 3'b001 loads the write pointer from bits 4:0. Opcode 3'b000 does nothing.
- R4: A data byte at pointer area 0 with an index of 0 to 12 writes all 8 bits into character cell `index`. A data byte at area 1 with an index of 0 to 12 writes bits 4:0 into annunciator cell `index`. Each such write increments the pointer.
- R5: When the pointer index (bits 3:0) is 13 or more, a data byte or a blink command at that pointer writes nothing and leaves the pointer unchanged.
- R6: Opcode 3'b110 writes bit 0 into character-blink cell `index` when the pointer is in area 0, then increments the pointer. The same command in area 1 writes nothing and does not move the pointer.
- R7: Opcode 3'b111 writes annunciator-blink cell `index` when the pointer is in area 1, then increments the pointer. The value written is bits 4:0 in 1-dot mode, and bit 0 copied into all five bits in 5-dot mode. The same command in area 0 writes nothing and does not move the pointer.
- R8: Opcode 3'b010 sets `disp_on` to bit 0. A value of 1 means display on and 0 means all-off.
- R9: Opcode 3'b011 sets `one_dot` to bit 0. A value of 1 selects 1-dot blink writes and 0 selects 5-dot blink writes.
- R10: Opcode 3'b100 clears all four memories only when bits 1:0 are both 1. Any other value in those bits has no effect on memories or flags.
- R11: Opcode 3'b101 sets `so_drive` to bit 0. A value of 1 drives the serial output and 0 leaves it high impedance.
- R12: After reset, `disp_on`, `one_dot`, `so_drive` and `proto_err` are 0 and every memory cell reads 0.
- R13: A byte that completes fewer than `MIN_GAP` clock cycles after the previous accepted byte is discarded, and `proto_err` pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial bit clock, sampled on rising edges |
| sdi | input | 1 | Serial data in, LSB first |
| cmd_sel | input | 1 | 1 = command byte, 0 = display data byte |
| chr_raddr | input | 4 | Scan read index for area-0 memories |
| ann_raddr | input | 4 | Scan read index for area-1 memories |
| chr_code | output | 8 | Character code at `chr_raddr` |
| chr_blink | output | 1 | Character blink bit at `chr_raddr` |
| ann_dots | output | 5 | Annunciator dots at `ann_raddr` |
| ann_blink | output | 5 | Annunciator blink bits at `ann_raddr` |
| disp_on | output | 1 | Display on (1) / all-off (0) |
| one_dot | output | 1 | Blink granularity: 1-dot (1) / 5-dot (0) |
| so_drive | output | 1 | Serial output driver enable |
| proto_err | output | 1 | One-cycle pulse when a byte arrives too early |

## Verification
The bench first fills the last character cell and then sends several more data bytes at the guard index. If the design let the pointer roll past the guard, it would reach area 1 and overwrite annunciator cell 0. If it wrote at the guard, the data would land in a wrong cell. Blink commands are also sent into the wrong area, followed by a data byte: a design that moved the pointer on a discarded blink write would put that data one cell too far. The bench covers 5-dot versus 1-dot blink expansion, a clear command with only one of its two bits set, a byte cut short by raising chip-select, and two bytes sent back to back. For the last case, a design without the gap check would store the second byte.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'b000,
      OP_LDPTR = 3'b001,
      OP_DISP  = 3'b010,
      OP_BMODE = 3'b011,
      OP_CLR   = 3'b100,
      OP_SOEN  = 3'b101,
      OP_CBLK  = 3'b110,
      OP_ABLK  = 3'b111
   } op_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/lcdl_ser_rx.sv
module lcdl_ser_rx #(
   parameter int MIN_GAP = 48,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic       sdi,
   input  logic       cmd_sel,
   output logic       byte_vld,
   output logic       byte_cmd,
   output logic [7:0] byte_data,
   output logic       proto_err
);
   localparam int GW = $clog2(MIN_GAP + 1);

   logic [SYNC_STAGES-1:0] cs_s, sck_s, sd_s, cd_s;
   logic       sck_d;
   logic [2:0] bit_cnt;
   logic [7:0] shreg;
   logic [GW-1:0] gap_cnt;
   logic       rise;
   logic [7:0] next_sh;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_GAP < 1) begin : g_bad_gap
         $error("MIN_GAP must be at least 1");
      end
      if (SYNC_STAGES == 2) begin : g_sync2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_s <= '1; sck_s <= '0; sd_s <= '0; cd_s <= '0;
            end else begin
               cs_s  <= {cs_s[0], cs_n};
               sck_s <= {sck_s[0], sclk};
               sd_s  <= {sd_s[0], sdi};
               cd_s  <= {cd_s[0], cmd_sel};
            end
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_s <= '1; sck_s <= '0; sd_s <= '0; cd_s <= '0;
            end else begin
               cs_s  <= {cs_s[SYNC_STAGES-2:0], cs_n};
               sck_s <= {sck_s[SYNC_STAGES-2:0], sclk};
               sd_s  <= {sd_s[SYNC_STAGES-2:0], sdi};
               cd_s  <= {cd_s[SYNC_STAGES-2:0], cmd_sel};
            end
         end
      end
   endgenerate

   assign rise    = sck_s[SYNC_STAGES-1] & ~sck_d;
   assign next_sh = {sd_s[SYNC_STAGES-1], shreg[7:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         bit_cnt   <= '0;
         shreg     <= '0;
         gap_cnt   <= '0;
         byte_vld  <= 1'b0;
         byte_cmd  <= 1'b0;
         byte_data <= '0;
         proto_err <= 1'b0;
      end else begin
         sck_d     <= sck_s[SYNC_STAGES-1];
         byte_vld  <= 1'b0;
         proto_err <= 1'b0;
         if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
         if (cs_s[SYNC_STAGES-1]) begin
            bit_cnt <= '0;
         end else if (rise) begin
            shreg   <= next_sh;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
               byte_data <= next_sh;
               byte_cmd  <= cd_s[SYNC_STAGES-1];
               if (gap_cnt != '0) begin
                  proto_err <= 1'b1;
               end else begin
                  byte_vld <= 1'b1;
                  gap_cnt  <= GW'(MIN_GAP);
               end
            end
         end
      end
   end

   // R1
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s[SYNC_STAGES-1] |=> (bit_cnt == 3'd0));

   // R13
   gap_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> !byte_vld);
endmodule

// File: rtl/lcdl_ram.sv
module lcdl_ram #(
   parameter int DEPTH = 13,
   parameter int W     = 8,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [DEPTH-1:0][W-1:0] mem;

   generate
      if (DEPTH >= (1 << AW)) begin : g_bad_depth
         $error("DEPTH must leave a guard index within AW bits");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (clr)                        q <= '0;
            else if (we && waddr == AW'(g))      q <= wdata;
         end
         assign mem[g] = q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (raddr < AW'(DEPTH)) rdata = mem[raddr];
   end

   // R5
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (waddr < AW'(DEPTH)));

   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mem == '0));
endmodule

// File: rtl/lcd_cmd_loader.sv
module lcd_cmd_loader
   import lcdl_pkg::*;
#(
   parameter int NCELL   = 13,
   parameter int CHR_W   = 8,
   parameter int DOT_W   = 5,
   parameter int MIN_GAP = 48
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cs_n,
   input  logic                          sclk,
   input  logic                          sdi,
   input  logic                          cmd_sel,
   input  logic [$clog2(NCELL)-1:0]      chr_raddr,
   input  logic [$clog2(NCELL)-1:0]      ann_raddr,
   output logic [CHR_W-1:0]              chr_code,
   output logic                          chr_blink,
   output logic [DOT_W-1:0]              ann_dots,
   output logic [DOT_W-1:0]              ann_blink,
   output logic                          disp_on,
   output logic                          one_dot,
   output logic                          so_drive,
   output logic                          proto_err
);
   localparam int AW = $clog2(NCELL);
   localparam int PW = AW + 1;

   generate
      if (NCELL >= (1 << AW)) begin : g_bad_ncell
         $error("NCELL must leave a guard index");
      end
      if (CHR_W != BYTE_W || DOT_W > BYTE_W || PW > 5) begin : g_bad_w
         $error("field widths do not fit the command byte");
      end
   endgenerate

   logic       b_vld, b_cmd;
   logic [7:0] b_dat;
   op_e        op;
   logic [PW-1:0] ptr;
   logic          area;
   logic [AW-1:0] idx;
   logic          inrng;
   logic          chr_we, ann_we, cbl_we, abl_we, clr;
   logic [DOT_W-1:0] abl_val;

   lcdl_ser_rx #(.MIN_GAP(MIN_GAP), .SYNC_STAGES(2)) rx_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .cmd_sel(cmd_sel), .byte_vld(b_vld), .byte_cmd(b_cmd),
      .byte_data(b_dat), .proto_err(proto_err));

   assign op    = op_e'(b_dat[7:5]);
   assign area  = ptr[PW-1];
   assign idx   = ptr[AW-1:0];
   assign inrng = idx < AW'(NCELL);

   always_comb begin
      chr_we  = b_vld && !b_cmd && !area && inrng;
      ann_we  = b_vld && !b_cmd &&  area && inrng;
      cbl_we  = b_vld &&  b_cmd && op == OP_CBLK && !area && inrng;
      abl_we  = b_vld &&  b_cmd && op == OP_ABLK &&  area && inrng;
      clr     = b_vld &&  b_cmd && op == OP_CLR && b_dat[1:0] == 2'b11;
      abl_val = one_dot ? b_dat[DOT_W-1:0] : {DOT_W{b_dat[0]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         disp_on  <= 1'b0;
         one_dot  <= 1'b0;
         so_drive <= 1'b0;
      end else begin
         if (b_vld && b_cmd && op == OP_LDPTR)
            ptr <= b_dat[PW-1:0];
         else if (chr_we || ann_we || cbl_we || abl_we)
            ptr <= ptr + 1'b1;
         if (b_vld && b_cmd) begin
            unique case (op)
               OP_DISP:  disp_on  <= b_dat[0];
               OP_BMODE: one_dot  <= b_dat[0];
               OP_SOEN:  so_drive <= b_dat[0];
               default: ;
            endcase
         end
      end
   end

   lcdl_ram #(.DEPTH(NCELL), .W(CHR_W), .AW(AW)) chr_ram_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(chr_we), .waddr(idx),
      .wdata(b_dat[CHR_W-1:0]), .raddr(chr_raddr), .rdata(chr_code));

   lcdl_ram #(.DEPTH(NCELL), .W(1), .AW(AW)) cbl_ram_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(cbl_we), .waddr(idx),
      .wdata(b_dat[0]), .raddr(chr_raddr), .rdata(chr_blink));

   lcdl_ram #(.DEPTH(NCELL), .W(DOT_W), .AW(AW)) ann_ram_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(ann_we), .waddr(idx),
      .wdata(b_dat[DOT_W-1:0]), .raddr(ann_raddr), .rdata(ann_dots));

   lcdl_ram #(.DEPTH(NCELL), .W(DOT_W), .AW(AW)) abl_ram_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(abl_we), .waddr(idx),
      .wdata(abl_val), .raddr(ann_raddr), .rdata(ann_blink));

   // R5
   guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && !b_cmd && !inrng) |=> (ptr == $past(ptr)));

   // R8
   disp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && b_cmd && b_dat[7:5] == 3'b010) |=> (disp_on == $past(b_dat[0])));

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && !b_cmd && inrng) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: tb/lcd_cmd_loader_tb_top.sv
module lcd_cmd_loader_tb_top;
   localparam int HP   = 2;
   localparam int IDLE = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, cmd_sel = 1'b0;
   logic [3:0] chr_raddr = '0, ann_raddr = '0;
   logic [7:0] chr_code;
   logic       chr_blink;
   logic [4:0] ann_dots, ann_blink;
   logic       disp_on, one_dot, so_drive, proto_err;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   bit err_seen = 0;

   always #5 clk = ~clk;

   lcd_cmd_loader dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .cmd_sel(cmd_sel), .chr_raddr(chr_raddr), .ann_raddr(ann_raddr),
      .chr_code(chr_code), .chr_blink(chr_blink), .ann_dots(ann_dots),
      .ann_blink(ann_blink), .disp_on(disp_on), .one_dot(one_dot),
      .so_drive(so_drive), .proto_err(proto_err));

   always @(posedge clk) if (proto_err) err_seen <= 1'b1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input bit cd, input logic [7:0] d, input int idle);
      @(negedge clk);
      cs_n = 1'b0; cmd_sel = cd;
      for (int i = 0; i < 8; i++) begin
         sdi = d[i]; sclk = 1'b0;
         repeat (HP) @(negedge clk);
         sclk = 1'b1;
         repeat (HP) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (idle) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] d); send_byte(1'b1, d, IDLE); endtask
   task automatic dat(input logic [7:0] d); send_byte(1'b0, d, IDLE); endtask

   task automatic rd_chr(input int i, output logic [7:0] code, output logic blk);
      @(negedge clk); chr_raddr = 4'(i); #1;
      code = chr_code; blk = chr_blink;
   endtask

   task automatic rd_ann(input int i, output logic [4:0] dots, output logic [4:0] blk);
      @(negedge clk); ann_raddr = 4'(i); #1;
      dots = ann_dots; blk = ann_blink;
   endtask

   task automatic t_reset();
      logic [7:0] c; logic b; logic [4:0] a, ab;
      chk(disp_on == 0, "R12 disp_on", disp_on, 0);
      chk(one_dot == 0, "R12 one_dot", one_dot, 0);
      chk(so_drive == 0, "R12 so_drive", so_drive, 0);
      chk(proto_err == 0, "R12 proto_err", proto_err, 0);
      rd_chr(0, c, b);  chk(c == 0 && b == 0, "R12 chr0", {c, b}, 0);
      rd_ann(12, a, ab); chk(a == 0 && ab == 0, "R12 ann12", {a, ab}, 0);
   endtask

   task automatic t_chars();
      logic [7:0] c; logic b; logic [4:0] a, ab;
      cmd(8'h20); dat(8'h41); dat(8'h42);
      rd_chr(0, c, b); chk(c == 8'h41, "R4 chr0", c, 8'h41);
      rd_chr(1, c, b); chk(c == 8'h42, "R2 R3 chr1", c, 8'h42);
      cmd(8'h2B); dat(8'h5B); dat(8'h5C);
      rd_chr(11, c, b); chk(c == 8'h5B, "R3 chr11", c, 8'h5B);
      rd_chr(12, c, b); chk(c == 8'h5C, "R4 chr12", c, 8'h5C);
      for (int k = 0; k < 4; k++) dat(8'h77);
      rd_chr(12, c, b); chk(c == 8'h5C, "R5 chr12 kept", c, 8'h5C);
      rd_chr(0, c, b);  chk(c == 8'h41, "R5 chr0 kept", c, 8'h41);
      rd_ann(0, a, ab); chk(a == 0, "R5 no roll into ann0", a, 0);
   endtask

   task automatic t_ann();
      logic [4:0] a, ab;
      cmd(8'h30); dat(8'h15); dat(8'hEA);
      rd_ann(0, a, ab); chk(a == 5'h15, "R4 ann0", a, 5'h15);
      rd_ann(1, a, ab); chk(a == 5'h0A, "R4 ann1", a, 5'h0A);
   endtask

   task automatic t_cblk();
      logic [7:0] c; logic b; logic [4:0] a, ab;
      cmd(8'h23); cmd(8'hC1); cmd(8'hC0); cmd(8'hC1);
      rd_chr(3, c, b); chk(b == 1, "R6 cblk3", b, 1);
      rd_chr(4, c, b); chk(b == 0, "R6 cblk4", b, 0);
      rd_chr(5, c, b); chk(b == 1, "R6 cblk5", b, 1);
      cmd(8'h32); cmd(8'hC1); dat(8'h07);
      rd_ann(2, a, ab); chk(a == 5'h07, "R6 wrong-area no step ann2", a, 5'h07);
      rd_ann(3, a, ab); chk(a == 5'h00, "R6 ann3 untouched", a, 0);
      rd_chr(2, c, b);  chk(b == 0, "R6 cblk2 untouched", b, 0);
   endtask

   task automatic t_ablk();
      logic [4:0] a, ab;
      cmd(8'h34); cmd(8'hE1); cmd(8'hFE);
      rd_ann(4, a, ab); chk(ab == 5'h1F, "R7 5-dot one", ab, 5'h1F);
      rd_ann(5, a, ab); chk(ab == 5'h00, "R7 5-dot zero", ab, 0);
      cmd(8'h61);
      chk(one_dot == 1, "R9 one_dot set", one_dot, 1);
      cmd(8'hEA);
      rd_ann(6, a, ab); chk(ab == 5'h0A, "R7 1-dot", ab, 5'h0A);
      cmd(8'h60);
      chk(one_dot == 0, "R9 one_dot clr", one_dot, 0);
   endtask

   task automatic t_flags();
      cmd(8'h41); chk(disp_on == 1, "R8 disp on", disp_on, 1);
      cmd(8'hA1); chk(so_drive == 1, "R11 so on", so_drive, 1);
      cmd(8'h00); chk(disp_on == 1 && so_drive == 1, "R3 nop", {disp_on, so_drive}, 3);
      cmd(8'h40); chk(disp_on == 0, "R8 disp off", disp_on, 0);
   endtask

   task automatic t_clear();
      logic [7:0] c; logic b; logic [4:0] a, ab;
      cmd(8'h81);
      rd_chr(0, c, b); chk(c == 8'h41, "R10 partial clear ignored", c, 8'h41);
      cmd(8'h82);
      rd_ann(0, a, ab); chk(a == 5'h15, "R10 partial clear ignored ann", a, 5'h15);
      cmd(8'h83);
      rd_chr(0, c, b);  chk(c == 0, "R10 chr0 cleared", c, 0);
      rd_chr(3, c, b);  chk(b == 0, "R10 cblk3 cleared", b, 0);
      rd_ann(0, a, ab); chk(a == 0, "R10 ann0 cleared", a, 0);
      rd_ann(4, a, ab); chk(ab == 0, "R10 ablk4 cleared", ab, 0);
      chk(so_drive == 1, "R10 flags kept", so_drive, 1);
   endtask

   task automatic t_abort();
      logic [7:0] c; logic b;
      cmd(8'h20);
      @(negedge clk); cs_n = 1'b0; cmd_sel = 1'b0;
      for (int i = 0; i < 3; i++) begin
         sdi = 1'b1; sclk = 1'b0; repeat (HP) @(negedge clk);
         sclk = 1'b1; repeat (HP) @(negedge clk);
      end
      sclk = 1'b0; cs_n = 1'b1;
      repeat (IDLE) @(negedge clk);
      dat(8'h5A);
      rd_chr(0, c, b); chk(c == 8'h5A, "R1 abort chr0", c, 8'h5A);
      rd_chr(1, c, b); chk(c == 8'h00, "R1 abort chr1", c, 0);
   endtask

   task automatic t_gap();
      logic [7:0] c; logic b;
      chk(err_seen == 0, "R13 no error on spaced traffic", err_seen, 0);
      cmd(8'h25);
      send_byte(1'b0, 8'h11, 0);
      send_byte(1'b0, 8'h22, IDLE);
      rd_chr(5, c, b); chk(c == 8'h11, "R13 first kept", c, 8'h11);
      rd_chr(6, c, b); chk(c == 8'h00, "R13 early byte dropped", c, 0);
      chk(err_seen == 1, "R13 proto_err pulse", err_seen, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_chars();
      t_ann();
      t_cblk();
      t_ablk();
      t_flags();
      t_clear();
      t_abort();
      t_gap();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule